// File: doc/BRIEF.md
# Dual-Source DRAM Queue Arbiter

This block feeds one shared DRAM command queue from two request sources: a coherent memory controller on the processor side and a non-coherent memory controller on the graphics side. Each source offers read or write requests, each with an address and a tag, over a valid/ready handshake. The processor-side request goes straight to the arbiter. The graphics-side request first goes through a small sideband FIFO, and the arbiter takes requests from the head of that FIFO.

For each source the arbiter counts the requests it has placed in the DRAM queue that have not yet completed. It refuses a source whose count has reached a programmed limit. Completions come back tagged with their source and free one slot each. When both sources are eligible, the winner is chosen by strict alternation by default. A mode bit switches to a fewest-outstanding-first policy, which breaks ties with the alternation pointer. A separate enable lets processor-side reads jump ahead of graphics traffic, because that side is sensitive to latency.

Top module: `dramq_dual_arb`

## Requirements
- R1: After reset both outstanding counts are zero, the alternation pointer favours the processor side, the sideband FIFO is empty, `dq_valid` and `cpu_req_ready` are low and `gfx_req_ready` is high.
- R2: A source whose outstanding count equals its limit (`cfg_cpu_cap` or `cfg_gfx_cap`) is never granted. While it stays there, `cpu_req_ready` is low for the processor side, or the FIFO head stays put for the graphics side.
- R3: With `cfg_fewest_mode`=0, when both sources are eligible and no read priority applies, grants alternate. After a grant the pointer favours the other source. `dq_src` encodes the processor side as 0 and the graphics side as 1.
- R4: With `cfg_fewest_mode`=1, when both sources are eligible and no read priority applies, the source with the smaller outstanding count is granted.
- R5: In fewest-outstanding mode, equal counts are resolved by the alternation pointer, exactly as in R3.
- R6: With `cfg_cpu_rd_prio`=1, an eligible processor-side read (`cpu_req_wr`=0) is granted ahead of any eligible graphics request.
- R7: With `cfg_cpu_rd_prio`=1, a processor-side write (`cpu_req_wr`=1) gets no priority and is arbitrated under the selected mode.
- R8: When only one source is eligible, it is presented on the queue port in the same cycle, with no wait for its turn.
- R9: A source's count rises on each grant and falls on each completion with `cpl_src` equal to that source. A grant and a completion in the same cycle leave the count unchanged. A completion at a count of zero is ignored.
- R10: The graphics FIFO holds 16 entries (4-bit read and write pointers). `gfx_req_ready` is low only while it is full. Graphics requests leave in the order they arrived, and none is lost.
- R11: A grant happens only in a cycle with `dq_ready` high. With `dq_ready` low nothing is consumed, no count changes and the pointer keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_cpu_cap | input | CNT_W (4) | Outstanding limit, processor side |
| cfg_gfx_cap | input | CNT_W (4) | Outstanding limit, graphics side |
| cfg_fewest_mode | input | 1 | 0 = alternation, 1 = fewest outstanding first |
| cfg_cpu_rd_prio | input | 1 | Processor-side reads take precedence |
| cpu_req_valid | input | 1 | Processor-side request valid |
| cpu_req_ready | output | 1 | Processor-side request accepted this cycle |
| cpu_req_wr | input | 1 | 1 = write, 0 = read |
| cpu_req_addr | input | ADDR_W (32) | Processor-side address |
| cpu_req_tag | input | TAG_W (8) | Processor-side tag |
| gfx_req_valid | input | 1 | Graphics request valid |
| gfx_req_ready | output | 1 | Sideband FIFO can take a request |
| gfx_req_wr | input | 1 | 1 = write, 0 = read |
| gfx_req_addr | input | ADDR_W (32) | Graphics address |
| gfx_req_tag | input | TAG_W (8) | Graphics tag |
| dq_valid | output | 1 | A request is offered to the DRAM queue |
| dq_ready | input | 1 | DRAM queue accepts the offered request |
| dq_src | output | 1 | Source of the offered request (0 processor, 1 graphics) |
| dq_wr | output | 1 | Offered request is a write |
| dq_addr | output | ADDR_W (32) | Offered address |
| dq_tag | output | TAG_W (8) | Offered tag |
| cpl_valid | input | 1 | A request completed in the DRAM queue |
| cpl_src | input | 1 | Source of the completed request |

## Verification
The bench tests the tie-break in fewest-outstanding mode with counts that meet halfway through a burst. A design that ignored the pointer, or compared the counts the wrong way, would give an order that differs from alternation at a known position. In read-priority runs, reads and a trailing write compete with queued graphics requests. A design that also promoted writes, or ignored the enable, would move the write or the reads. Grants are placed in the same cycle as completions, and completions are also sent at a count of zero. A counter that dropped either event would block a request too early, or would wrap and lock the source out. The 16-entry FIFO is filled to its limit while the queue stalls, so lost, duplicated or reordered entries show up when it drains.

// File: rtl/dqa_pkg.sv
package dqa_pkg;

   // Source encoding on dq_src and cpl_src.
   typedef enum logic {
      SRC_CPU = 1'b0,
      SRC_GFX = 1'b1
   } dqa_src_e;

   localparam int unsigned NUM_SRC = 2;

endpackage

// File: rtl/dqa_sb_fifo.sv
module dqa_sb_fifo #(
   parameter int unsigned W     = 41,
   parameter int unsigned DEPTH = 16
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           push,
   input  logic [W-1:0]                   push_data,
   output logic                           full,
   input  logic                           pop,
   output logic [W-1:0]                   head,
   output logic                           empty,
   output logic [$clog2(DEPTH+1)-1:0]     level
);

   localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int unsigned LVL_W = $clog2(DEPTH + 1);
   localparam bit          POW2  = ((DEPTH & (DEPTH - 1)) == 0);

   if (DEPTH < 2) begin : g_bad_depth
      $error("dqa_sb_fifo: DEPTH must be at least 2");
   end
   if (W < 1) begin : g_bad_width
      $error("dqa_sb_fifo: W must be at least 1");
   end

   logic [W-1:0]     store [DEPTH];
   logic [PTR_W-1:0] wr_ptr, rd_ptr, wr_nxt, rd_nxt;
   logic [LVL_W-1:0] cnt_q;
   logic             do_push, do_pop;

   assign full    = (cnt_q == LVL_W'(DEPTH));
   assign empty   = (cnt_q == '0);
   assign level   = cnt_q;
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;
   assign head    = store[rd_ptr];

   // Pointer stepping: natural wrap for power-of-two depths, explicit otherwise.
   if (POW2) begin : g_wrap_pow2
      assign wr_nxt = wr_ptr + PTR_W'(1);
      assign rd_nxt = rd_ptr + PTR_W'(1);
   end else begin : g_wrap_mod
      assign wr_nxt = (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + PTR_W'(1);
      assign rd_nxt = (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + PTR_W'(1);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         cnt_q  <= '0;
      end else begin
         if (do_push) begin
            wr_ptr <= wr_nxt;
         end
         if (do_pop) begin
            rd_ptr <= rd_nxt;
         end
         case ({do_push, do_pop})
            2'b10:   cnt_q <= cnt_q + LVL_W'(1);
            2'b01:   cnt_q <= cnt_q - LVL_W'(1);
            default: cnt_q <= cnt_q;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (do_push) begin
         store[wr_ptr] <= push_data;
      end
   end

endmodule

// File: rtl/dqa_out_ctr.sv
module dqa_out_ctr #(
   parameter int unsigned CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inc,
   input  logic             dec,
   output logic [CNT_W-1:0] count
);

   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   logic [CNT_W-1:0] cnt_q;
   logic             dec_ok, inc_ok;

   // A completion with nothing outstanding is dropped; growth stops at the maximum.
   assign dec_ok = dec && ((cnt_q != '0) || inc);
   assign inc_ok = inc && ((cnt_q != CNT_MAX) || dec_ok);
   assign count  = cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else begin
         case ({inc_ok, dec_ok})
            2'b10:   cnt_q <= cnt_q + CNT_W'(1);
            2'b01:   cnt_q <= cnt_q - CNT_W'(1);
            default: cnt_q <= cnt_q;
         endcase
      end
   end

endmodule

// File: rtl/dqa_policy.sv
module dqa_policy #(
   parameter int unsigned CNT_W        = 4,
   parameter bit          ALLOW_FEWEST = 1'b1
) (
   input  logic             cpu_elig,
   input  logic             gfx_elig,
   input  logic             cpu_is_rd,
   input  logic             rd_prio_en,
   input  logic             fewest_mode,
   input  logic             favor_gfx,
   input  logic [CNT_W-1:0] cpu_cnt,
   input  logic [CNT_W-1:0] gfx_cnt,
   output logic             any_elig,
   output logic             pick_gfx
);

   logic mode_pick_gfx;

   // Choice used when both sides contend and no read override applies.
   if (ALLOW_FEWEST) begin : g_fewest
      always_comb begin
         if (!fewest_mode) begin
            mode_pick_gfx = favor_gfx;
         end else if (gfx_cnt < cpu_cnt) begin
            mode_pick_gfx = 1'b1;
         end else if (cpu_cnt < gfx_cnt) begin
            mode_pick_gfx = 1'b0;
         end else begin
            mode_pick_gfx = favor_gfx;
         end
      end
   end else begin : g_alt_only
      logic unused_mode;
      assign unused_mode   = fewest_mode ^ (^cpu_cnt) ^ (^gfx_cnt);
      assign mode_pick_gfx = favor_gfx;
   end

   always_comb begin
      any_elig = cpu_elig || gfx_elig;
      if (!(cpu_elig && gfx_elig)) begin
         pick_gfx = gfx_elig;
      end else if (rd_prio_en && cpu_is_rd) begin
         pick_gfx = 1'b0;
      end else begin
         pick_gfx = mode_pick_gfx;
      end
   end

endmodule

// File: rtl/dramq_dual_arb.sv
module dramq_dual_arb
   import dqa_pkg::*;
#(
   parameter int unsigned ADDR_W       = 32,
   parameter int unsigned TAG_W        = 8,
   parameter int unsigned GFX_DEPTH    = 16,
   parameter int unsigned MAX_OUT      = 15,
   parameter bit          ALLOW_FEWEST = 1'b1
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic [$clog2(MAX_OUT+1)-1:0]   cfg_cpu_cap,
   input  logic [$clog2(MAX_OUT+1)-1:0]   cfg_gfx_cap,
   input  logic                           cfg_fewest_mode,
   input  logic                           cfg_cpu_rd_prio,
   input  logic                           cpu_req_valid,
   output logic                           cpu_req_ready,
   input  logic                           cpu_req_wr,
   input  logic [ADDR_W-1:0]              cpu_req_addr,
   input  logic [TAG_W-1:0]               cpu_req_tag,
   input  logic                           gfx_req_valid,
   output logic                           gfx_req_ready,
   input  logic                           gfx_req_wr,
   input  logic [ADDR_W-1:0]              gfx_req_addr,
   input  logic [TAG_W-1:0]               gfx_req_tag,
   output logic                           dq_valid,
   input  logic                           dq_ready,
   output logic                           dq_src,
   output logic                           dq_wr,
   output logic [ADDR_W-1:0]              dq_addr,
   output logic [TAG_W-1:0]               dq_tag,
   input  logic                           cpl_valid,
   input  logic                           cpl_src
);

   localparam int unsigned CNT_W = $clog2(MAX_OUT + 1);
   localparam int unsigned PKT_W = 1 + ADDR_W + TAG_W;
   localparam int unsigned LVL_W = $clog2(GFX_DEPTH + 1);

   if (MAX_OUT < 1) begin : g_bad_max
      $error("dramq_dual_arb: MAX_OUT must be at least 1");
   end
   if (ADDR_W < 1 || TAG_W < 1) begin : g_bad_fields
      $error("dramq_dual_arb: ADDR_W and TAG_W must be non-zero");
   end

   // ---------------- graphics sideband FIFO ----------------
   logic [PKT_W-1:0]  gfx_in_pkt, gfx_head;
   logic              gfx_full, gfx_empty, gfx_pop;
   logic [LVL_W-1:0]  gfx_level;
   logic              gfx_hd_wr;
   logic [ADDR_W-1:0] gfx_hd_addr;
   logic [TAG_W-1:0]  gfx_hd_tag;

   assign gfx_in_pkt = {gfx_req_wr, gfx_req_addr, gfx_req_tag};

   dqa_sb_fifo #(
      .W     (PKT_W),
      .DEPTH (GFX_DEPTH)
   ) u_gfx_fifo (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (gfx_req_valid),
      .push_data (gfx_in_pkt),
      .full      (gfx_full),
      .pop       (gfx_pop),
      .head      (gfx_head),
      .empty     (gfx_empty),
      .level     (gfx_level)
   );

   assign gfx_req_ready = !gfx_full;
   assign {gfx_hd_wr, gfx_hd_addr, gfx_hd_tag} = gfx_head;

   // ---------------- outstanding counters ----------------
   logic [NUM_SRC-1:0]            ctr_inc, ctr_dec, has_room;
   logic [NUM_SRC-1:0][CNT_W-1:0] ctr_cnt, ctr_cap;
   logic [CNT_W-1:0]              cpu_cnt, gfx_cnt;

   assign ctr_cap[SRC_CPU] = cfg_cpu_cap;
   assign ctr_cap[SRC_GFX] = cfg_gfx_cap;

   for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
      dqa_out_ctr #(
         .CNT_W (CNT_W)
      ) u_ctr (
         .clk   (clk),
         .rst_n (rst_n),
         .inc   (ctr_inc[s]),
         .dec   (ctr_dec[s]),
         .count (ctr_cnt[s])
      );
      assign ctr_dec[s]  = cpl_valid && (cpl_src == 1'(s));
      assign has_room[s] = (ctr_cnt[s] < ctr_cap[s]);
   end

   assign cpu_cnt = ctr_cnt[SRC_CPU];
   assign gfx_cnt = ctr_cnt[SRC_GFX];

   // ---------------- selection ----------------
   logic cpu_elig, gfx_elig, any_elig, pick_gfx, grant;
   logic favor_gfx;

   assign cpu_elig = cpu_req_valid && has_room[SRC_CPU];
   assign gfx_elig = !gfx_empty && has_room[SRC_GFX];

   dqa_policy #(
      .CNT_W        (CNT_W),
      .ALLOW_FEWEST (ALLOW_FEWEST)
   ) u_policy (
      .cpu_elig    (cpu_elig),
      .gfx_elig    (gfx_elig),
      .cpu_is_rd   (!cpu_req_wr),
      .rd_prio_en  (cfg_cpu_rd_prio),
      .fewest_mode (cfg_fewest_mode),
      .favor_gfx   (favor_gfx),
      .cpu_cnt     (cpu_cnt),
      .gfx_cnt     (gfx_cnt),
      .any_elig    (any_elig),
      .pick_gfx    (pick_gfx)
   );

   assign grant            = any_elig && dq_ready;
   assign cpu_req_ready    = grant && !pick_gfx;
   assign gfx_pop          = grant && pick_gfx;
   assign ctr_inc[SRC_CPU] = cpu_req_ready;
   assign ctr_inc[SRC_GFX] = gfx_pop;

   // Pointer moves only on an issued grant, toward the other source.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         favor_gfx <= 1'b0;
      end else if (grant) begin
         favor_gfx <= !pick_gfx;
      end
   end

   // ---------------- queue port ----------------
   always_comb begin
      dq_valid = any_elig;
      dq_src   = pick_gfx ? SRC_GFX : SRC_CPU;
      if (pick_gfx) begin
         dq_wr   = gfx_hd_wr;
         dq_addr = gfx_hd_addr;
         dq_tag  = gfx_hd_tag;
      end else begin
         dq_wr   = cpu_req_wr;
         dq_addr = cpu_req_addr;
         dq_tag  = cpu_req_tag;
      end
   end

endmodule

// File: rtl/dramq_dual_arb_chk.sv
module dramq_dual_arb_chk #(
   parameter int unsigned CNT_W = 4,
   parameter int unsigned LVL_W = 5,
   parameter int unsigned DEPTH = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic [CNT_W-1:0] cfg_cpu_cap,
   input logic [CNT_W-1:0] cfg_gfx_cap,
   input logic             cfg_fewest_mode,
   input logic             cfg_cpu_rd_prio,
   input logic             cpu_req_valid,
   input logic             cpu_req_wr,
   input logic             cpu_req_ready,
   input logic             gfx_req_ready,
   input logic             dq_valid,
   input logic             dq_ready,
   input logic             dq_src,
   input logic [CNT_W-1:0] cpu_cnt,
   input logic [CNT_W-1:0] gfx_cnt,
   input logic             cpu_elig,
   input logic             gfx_elig,
   input logic             gfx_pop,
   input logic [LVL_W-1:0] gfx_level,
   input logic [1:0]       ctr_inc,
   input logic [1:0]       ctr_dec
);

   // R2
   cpu_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dq_valid && dq_ready && dq_src == 1'b0) |-> (cpu_cnt < cfg_cpu_cap));

   // R2
   gfx_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dq_valid && dq_ready && dq_src == 1'b1) |-> (gfx_cnt < cfg_gfx_cap));

   // R8
   lone_cpu_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_elig && !gfx_elig) |-> (dq_valid && dq_src == 1'b0));

   // R8
   lone_gfx_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (gfx_elig && !cpu_elig) |-> (dq_valid && dq_src == 1'b1));

   // R6
   rd_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_cpu_rd_prio && cpu_elig && !cpu_req_wr) |-> (dq_src == 1'b0));

   // R3
   alternate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(dq_valid && dq_ready && cpu_elig && gfx_elig && !cfg_fewest_mode
                              && !(cfg_cpu_rd_prio && !cpu_req_wr))
       && cpu_elig && gfx_elig && !cfg_fewest_mode && !(cfg_cpu_rd_prio && !cpu_req_wr))
      |-> (dq_src != $past(dq_src)));

   // R9
   cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(ctr_inc[0] && ctr_dec[0])) |-> (cpu_cnt == $past(cpu_cnt)));

   // R9
   cnt_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(ctr_inc[1] && !ctr_dec[1])) |-> (gfx_cnt == $past(gfx_cnt) + CNT_W'(1)));

   // R10
   fifo_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      gfx_req_ready |-> (gfx_level < LVL_W'(DEPTH)));

   // R11
   no_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !dq_ready |-> (!cpu_req_ready && !gfx_pop));

   // R11
   no_ready_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(!dq_ready && !ctr_dec[0])) |-> $stable(cpu_cnt));

endmodule

bind dramq_dual_arb dramq_dual_arb_chk #(
   .CNT_W (CNT_W),
   .LVL_W (LVL_W),
   .DEPTH (GFX_DEPTH)
) u_chk (
   .clk             (clk),
   .rst_n           (rst_n),
   .cfg_cpu_cap     (cfg_cpu_cap),
   .cfg_gfx_cap     (cfg_gfx_cap),
   .cfg_fewest_mode (cfg_fewest_mode),
   .cfg_cpu_rd_prio (cfg_cpu_rd_prio),
   .cpu_req_valid   (cpu_req_valid),
   .cpu_req_wr      (cpu_req_wr),
   .cpu_req_ready   (cpu_req_ready),
   .gfx_req_ready   (gfx_req_ready),
   .dq_valid        (dq_valid),
   .dq_ready        (dq_ready),
   .dq_src          (dq_src),
   .cpu_cnt         (cpu_cnt),
   .gfx_cnt         (gfx_cnt),
   .cpu_elig        (cpu_elig),
   .gfx_elig        (gfx_elig),
   .gfx_pop         (gfx_pop),
   .gfx_level       (gfx_level),
   .ctr_inc         (ctr_inc),
   .ctr_dec         (ctr_dec)
);

// File: tb/dramq_dual_arb_tb_top.sv
`timescale 1ns/1ps
module dramq_dual_arb_tb_top;

   localparam int AW = 32;
   localparam int TW = 8;
   localparam int CW = 4;

   typedef struct packed {
      logic          src;
      logic          wr;
      logic [AW-1:0] addr;
      logic [TW-1:0] tag;
   } item_t;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [CW-1:0] cfg_cpu_cap = 4'd8;
   logic [CW-1:0] cfg_gfx_cap = 4'd8;
   logic          cfg_fewest_mode = 1'b0;
   logic          cfg_cpu_rd_prio = 1'b0;
   logic          cpu_req_valid = 1'b0;
   logic          cpu_req_ready;
   logic          cpu_req_wr = 1'b0;
   logic [AW-1:0] cpu_req_addr = '0;
   logic [TW-1:0] cpu_req_tag = '0;
   logic          gfx_req_valid = 1'b0;
   logic          gfx_req_ready;
   logic          gfx_req_wr = 1'b0;
   logic [AW-1:0] gfx_req_addr = '0;
   logic [TW-1:0] gfx_req_tag = '0;
   logic          dq_valid;
   logic          dq_ready = 1'b0;
   logic          dq_src;
   logic          dq_wr;
   logic [AW-1:0] dq_addr;
   logic [TW-1:0] dq_tag;
   logic          cpl_valid = 1'b0;
   logic          cpl_src = 1'b0;

   always #2.5 clk = ~clk;

   dramq_dual_arb dut_i (
      .clk             (clk),
      .rst_n           (rst_n),
      .cfg_cpu_cap     (cfg_cpu_cap),
      .cfg_gfx_cap     (cfg_gfx_cap),
      .cfg_fewest_mode (cfg_fewest_mode),
      .cfg_cpu_rd_prio (cfg_cpu_rd_prio),
      .cpu_req_valid   (cpu_req_valid),
      .cpu_req_ready   (cpu_req_ready),
      .cpu_req_wr      (cpu_req_wr),
      .cpu_req_addr    (cpu_req_addr),
      .cpu_req_tag     (cpu_req_tag),
      .gfx_req_valid   (gfx_req_valid),
      .gfx_req_ready   (gfx_req_ready),
      .gfx_req_wr      (gfx_req_wr),
      .gfx_req_addr    (gfx_req_addr),
      .gfx_req_tag     (gfx_req_tag),
      .dq_valid        (dq_valid),
      .dq_ready        (dq_ready),
      .dq_src          (dq_src),
      .dq_wr           (dq_wr),
      .dq_addr         (dq_addr),
      .dq_tag          (dq_tag),
      .cpl_valid       (cpl_valid),
      .cpl_src         (cpl_src)
   );

   int    n_checks = 0;
   int    n_errors = 0;
   item_t cpu_q[$];
   item_t gfx_q[$];
   item_t exp_q[$];
   string exp_req[$];
   logic  cpu_fire = 1'b0;
   logic  gfx_fire = 1'b0;

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      n_checks++;
      if (!ok) begin
         n_errors++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(posedge clk);
      #2;
   endtask

   task automatic cpu_push(input bit wr, input int addr, input int tag);
      cpu_q.push_back('{src: 1'b0, wr: wr, addr: AW'(addr), tag: TW'(tag)});
   endtask

   task automatic gfx_push(input bit wr, input int addr, input int tag);
      gfx_q.push_back('{src: 1'b1, wr: wr, addr: AW'(addr), tag: TW'(tag)});
   endtask

   task automatic expect_item(input bit src, input bit wr, input int addr, input int tag,
                              input string req);
      exp_q.push_back('{src: src, wr: wr, addr: AW'(addr), tag: TW'(tag)});
      exp_req.push_back(req);
   endtask

   task automatic complete(input bit src, input int n);
      for (int i = 0; i < n; i++) begin
         cpl_valid = 1'b1;
         cpl_src   = src;
         step(1);
      end
      cpl_valid = 1'b0;
   endtask

   task automatic wait_drain(input string req);
      int n = 0;
      while (exp_q.size() > 0 && n < 300) begin
         step(1);
         n++;
      end
      check(exp_q.size() == 0, req, exp_q.size(), 0);
   endtask

   // Monitor: sample handshakes between edges and score queue grants.
   always @(negedge clk) begin
      cpu_fire = cpu_req_valid && cpu_req_ready;
      gfx_fire = gfx_req_valid && gfx_req_ready;
      if (rst_n && dq_valid && dq_ready) begin
         item_t got;
         got = '{src: dq_src, wr: dq_wr, addr: dq_addr, tag: dq_tag};
         if (exp_q.size() == 0) begin
            check(1'b0, "R11 unexpected grant", got, 0);
         end else begin
            item_t want;
            string req;
            want = exp_q.pop_front();
            req  = exp_req.pop_front();
            check(got == want, req, got, want);
         end
      end
   end

   // Drivers: present queue heads, retire on observed handshake.
   always @(posedge clk) begin
      if (cpu_fire) void'(cpu_q.pop_front());
      if (gfx_fire) void'(gfx_q.pop_front());
      #1;
      if (cpu_q.size() > 0) begin
         cpu_req_valid = 1'b1;
         cpu_req_wr    = cpu_q[0].wr;
         cpu_req_addr  = cpu_q[0].addr;
         cpu_req_tag   = cpu_q[0].tag;
      end else begin
         cpu_req_valid = 1'b0;
      end
      if (gfx_q.size() > 0) begin
         gfx_req_valid = 1'b1;
         gfx_req_wr    = gfx_q[0].wr;
         gfx_req_addr  = gfx_q[0].addr;
         gfx_req_tag   = gfx_q[0].tag;
      end else begin
         gfx_req_valid = 1'b0;
      end
   end

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      check(1'b0, "watchdog expired", 0, 1);
      finish_run();
   end

   initial begin
      step(4);
      // R1: reset state
      check(dq_valid == 1'b0, "R1 dq_valid in reset", dq_valid, 0);
      rst_n = 1'b1;
      step(2);
      check(dq_valid == 1'b0, "R1 dq_valid after reset", dq_valid, 0);
      check(gfx_req_ready == 1'b1, "R1 gfx_req_ready", gfx_req_ready, 1);
      check(cpu_req_ready == 1'b0, "R1 cpu_req_ready", cpu_req_ready, 0);

      // R3/R8/R11: alternation, graphics preloaded while queue stalls
      for (int i = 0; i < 3; i++) gfx_push(1'b0, 'h2000 + i, 'h40 + i);
      step(6);
      check(dq_valid && dq_src == 1'b1, "R8 lone graphics offered", {dq_valid, dq_src}, 2'b11);
      check(cpu_req_ready == 1'b0, "R11 no accept while stalled", cpu_req_ready, 0);
      for (int i = 0; i < 3; i++) cpu_push(1'b0, 'h1000 + i, 'h10 + i);
      for (int i = 0; i < 3; i++) begin
         expect_item(1'b0, 1'b0, 'h1000 + i, 'h10 + i, "R3 alternation cpu");
         expect_item(1'b1, 1'b0, 'h2000 + i, 'h40 + i, "R3 alternation gfx");
      end
      step(1);
      dq_ready = 1'b1;
      wait_drain("R3 alternation drained");
      complete(1'b0, 3);
      complete(1'b1, 3);

      // R2/R9: cap, simultaneous grant and completion, completion at zero
      cfg_cpu_cap = 4'd2;
      cpu_push(1'b1, 'h1100, 'h20);
      expect_item(1'b0, 1'b1, 'h1100, 'h20, "R8 lone cpu");
      step(3);
      cpu_push(1'b0, 'h1101, 'h21);
      cpu_push(1'b0, 'h1102, 'h22);
      cpu_push(1'b0, 'h1103, 'h23);
      expect_item(1'b0, 1'b0, 'h1101, 'h21, "R9 grant with completion");
      expect_item(1'b0, 1'b0, 'h1102, 'h22, "R9 count held");
      step(1);
      cpl_valid = 1'b1;
      cpl_src   = 1'b0;
      step(1);
      cpl_valid = 1'b0;
      step(4);
      check(exp_q.size() == 0, "R9 same-cycle inc and dec", exp_q.size(), 0);
      check(cpu_req_ready == 1'b0 && dq_valid == 1'b0, "R2 cpu blocked at cap",
            {cpu_req_ready, dq_valid}, 0);
      expect_item(1'b0, 1'b0, 'h1103, 'h23, "R9 slot freed");
      complete(1'b0, 1);
      step(3);
      check(exp_q.size() == 0, "R9 slot freed", exp_q.size(), 0);
      complete(1'b0, 2);
      complete(1'b0, 1);
      cfg_cpu_cap = 4'd1;
      cpu_push(1'b0, 'h1200, 'h30);
      cpu_push(1'b0, 'h1201, 'h31);
      expect_item(1'b0, 1'b0, 'h1200, 'h30, "R9 completion at zero ignored");
      step(5);
      check(exp_q.size() == 0, "R9 completion at zero ignored", exp_q.size(), 0);
      check(cpu_req_ready == 1'b0, "R2 cap of one", cpu_req_ready, 0);
      expect_item(1'b0, 1'b0, 'h1201, 'h31, "R2 released by completion");
      complete(1'b0, 1);
      step(3);
      check(exp_q.size() == 0, "R2 released by completion", exp_q.size(), 0);
      complete(1'b0, 1);

      // R4/R5: fewest outstanding with tie-break by pointer
      cfg_cpu_cap     = 4'd8;
      cfg_fewest_mode = 1'b1;
      gfx_push(1'b0, 'h2100, 'h50);
      gfx_push(1'b0, 'h2101, 'h51);
      expect_item(1'b1, 1'b0, 'h2100, 'h50, "R8 gfx alone");
      expect_item(1'b1, 1'b0, 'h2101, 'h51, "R8 gfx alone");
      wait_drain("R8 gfx alone drained");
      step(2);
      dq_ready = 1'b0;
      for (int i = 0; i < 3; i++) gfx_push(1'b1, 'h2200 + i, 'h60 + i);
      for (int i = 0; i < 3; i++) cpu_push(1'b0, 'h1300 + i, 'h70 + i);
      step(5);
      expect_item(1'b0, 1'b0, 'h1300, 'h70, "R4 fewer outstanding wins");
      expect_item(1'b0, 1'b0, 'h1301, 'h71, "R4 fewer outstanding wins");
      expect_item(1'b1, 1'b1, 'h2200, 'h60, "R5 tie uses pointer");
      expect_item(1'b0, 1'b0, 'h1302, 'h72, "R4 fewer outstanding wins");
      expect_item(1'b1, 1'b1, 'h2201, 'h61, "R5 tie uses pointer");
      expect_item(1'b1, 1'b1, 'h2202, 'h62, "R8 gfx alone");
      dq_ready = 1'b1;
      wait_drain("R4 fewest drained");
      complete(1'b0, 3);
      complete(1'b1, 5);

      // R6/R7: read priority, writes arbitrated normally
      cfg_fewest_mode = 1'b0;
      cfg_cpu_rd_prio = 1'b1;
      dq_ready = 1'b0;
      gfx_push(1'b0, 'h2300, 'h80);
      gfx_push(1'b0, 'h2301, 'h81);
      cpu_push(1'b0, 'h1400, 'h90);
      cpu_push(1'b0, 'h1401, 'h91);
      cpu_push(1'b1, 'h1402, 'h92);
      step(4);
      check(dq_src == 1'b0, "R6 cpu read offered first", dq_src, 0);
      expect_item(1'b0, 1'b0, 'h1400, 'h90, "R6 read priority");
      expect_item(1'b0, 1'b0, 'h1401, 'h91, "R6 read priority");
      expect_item(1'b1, 1'b0, 'h2300, 'h80, "R7 write not prioritised");
      expect_item(1'b0, 1'b1, 'h1402, 'h92, "R7 write not prioritised");
      expect_item(1'b1, 1'b0, 'h2301, 'h81, "R7 write not prioritised");
      dq_ready = 1'b1;
      wait_drain("R6 priority drained");
      complete(1'b0, 3);
      complete(1'b1, 2);
      cfg_cpu_rd_prio = 1'b0;

      // R10: fill FIFO to 16 while stalled, then drain in order
      dq_ready = 1'b0;
      for (int i = 0; i < 17; i++) gfx_push(i[0], 'h3000 + i, 'hA0 + i);
      step(22);
      check(gfx_req_ready == 1'b0, "R10 full after 16", gfx_req_ready, 0);
      check(gfx_req_valid == 1'b1, "R10 17th request held", gfx_req_valid, 1);
      for (int i = 0; i < 17; i++) expect_item(1'b1, i[0], 'h3000 + i, 'hA0 + i, "R10 order kept");
      cpl_valid = 1'b1;
      cpl_src   = 1'b1;
      dq_ready  = 1'b1;
      wait_drain("R10 all drained");
      step(2);
      cpl_valid = 1'b0;
      step(2);
      check(gfx_req_ready == 1'b1, "R10 ready after drain", gfx_req_ready, 1);
      check(dq_valid == 1'b0, "R10 nothing left", dq_valid, 0);

      finish_run();
   end

endmodule